// File: doc/BRIEF.md
# Receiver Channel Reset Sequencer

This block brings a serial receiver channel out of reset in a safe order. It holds the analog reset while calibration runs. It then handshakes the assertion and the release of that reset with the analog section through an acknowledge line. After that it waits for the clock-data-recovery circuit to report lock to incoming data. The digital reset is released only once lock has stayed up for a minimum settling interval. The interval is given in microseconds and turned into a cycle count from the clock frequency, rounded up.

In operation the sequencer watches for loss of lock. When lock is lost it reasserts the digital reset and waits for lock again. Software can pulse the digital reset alone, or restart the whole sequence including the analog reset. If an acknowledge does not arrive within a set number of cycles, the block flags a one-cycle error and retries the analog step. All status inputs are asynchronous and pass through two-flop synchronizers. A change on any status input therefore reaches the sequencing logic on the third rising edge after it occurs. The two software request inputs are synchronous to the clock.

Top module: `rx_rst_seq`

## Requirements
- R1: While reset is low, and afterwards for as long as the calibration-busy input stays high, analog reset and digital reset are 1, ready is 0 and the error output is 0.
- R2: The analog reset stays 1 until the acknowledge input has been high. The analog reset falls on the third rising edge after the acknowledge rises while the block waits for it.
- R3: After the analog reset is released, the digital reset stays 1 until the acknowledge input has gone low and lock has been reported.
- R4: With the acknowledge low and lock rising while the block waits for lock, the digital reset falls on rising edge SETTLE+3. SETTLE is ceil(CLK_FREQ_HZ × SETTLE_US / 1,000,000).
- R5: If lock drops at any point in the settling interval, the count restarts. The digital reset then falls on rising edge SETTLE+3 after lock returns.
- R6: Whenever the analog reset is 1, the digital reset is also 1.
- R7: Ready is 1 exactly when both resets are 0, in the same cycle.
- R8: A one-cycle digital-only request while ready holds the digital reset at 1 for DIG_PULSE_CYC cycles, starting after the next rising edge. The analog reset stays 0 throughout. Ready returns afterwards if lock held.
- R9: Loss of lock while ready sets the digital reset to 1 on the third rising edge after lock falls. The analog reset stays 0.
- R10: If the acknowledge does not change within ACK_TMO_CYC cycles of waiting, the error output is 1 for one cycle. A timeout while waiting for the acknowledge to rise restarts that wait. A timeout while waiting for it to fall reasserts the analog reset and retries the handshake.
- R11: A full-restart request, outside the calibration wait, sets the analog reset and the digital reset to 1 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_busy_i | input | 1 | Calibration in progress (asynchronous) |
| ana_ack_i | input | 1 | Analog reset acknowledge (asynchronous) |
| cdr_lock_i | input | 1 | Recovery circuit locked to data (asynchronous) |
| sw_full_req_i | input | 1 | Software full-restart request (synchronous) |
| sw_dig_req_i | input | 1 | Software digital-only reset request (synchronous) |
| ana_rst_o | output | 1 | Analog reset to the receiver front end |
| dig_rst_o | output | 1 | Digital reset to the receiver logic |
| ready_o | output | 1 | Channel out of reset |
| ack_err_o | output | 1 | One-cycle pulse on handshake timeout |

## Verification
The assertions on release timing look back exactly three cycles on the raw inputs. They assume each status input holds steady for at least two clock edges around a change, so that the synchronizer passes the value without a glitch. The bench drives every input just after a falling clock edge and holds each level for at least one full cycle. It raises acknowledge and lock only when the sequencer is waiting for them. Each lock glitch in the settling sweep lasts one whole cycle, so the synchronized value always shows the drop.

// File: rtl/rx_rst_pkg.sv
// Shared types for the receiver reset sequencer.
// Assumes: consumers decode outputs only through seq_decode.
package rx_rst_pkg;

    typedef enum logic [2:0] {
        ST_CAL_WAIT    = 3'd0,
        ST_ANA_ASSERT  = 3'd1,
        ST_ANA_RELEASE = 3'd2,
        ST_LOCK_WAIT   = 3'd3,
        ST_SETTLE      = 3'd4,
        ST_RUN         = 3'd5,
        ST_DIG_PULSE   = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic ana;
        logic dig;
        logic rdy;
    } rst_out_t;

    // Map a sequencer state onto the three reset outputs.
    function automatic rst_out_t seq_decode(seq_state_e s);
        rst_out_t o;
        case (s)
            ST_CAL_WAIT, ST_ANA_ASSERT: o = '{ana: 1'b1, dig: 1'b1, rdy: 1'b0};
            ST_RUN:                     o = '{ana: 1'b0, dig: 1'b0, rdy: 1'b1};
            default:                    o = '{ana: 1'b0, dig: 1'b1, rdy: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/rx_rst_sync.sv
// Two-flop synchronizer bank, one chain per input bit.
// Assumes: inputs are single-bit levels with no relation to one another.
module rx_rst_sync #(
    parameter int unsigned W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_chain
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= async_i[i];
                stab_q <= meta_q;
            end
        end

        assign sync_o[i] = stab_q;
    end

endmodule

// File: rtl/rx_rst_timer.sv
// Saturating cycle counter shared by every timed state of the sequencer.
// Assumes: clr is raised in the cycle a new interval must start from zero.
module rx_rst_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt_o
);

    // Count up from zero after clr and hold at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (cnt_o != '1) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/rx_rst_fsm.sv
// Sequencing state machine: calibration wait, analog handshakes,
// lock wait, settling count, run, and the digital-only pulse.
// Assumes: status inputs are already synchronized, and the timer restarts
// whenever restart_o is high.
module rx_rst_fsm
    import rx_rst_pkg::*;
#(
    parameter int unsigned SETTLE_CYC    = 500,
    parameter int unsigned ACK_TMO_CYC   = 1000,
    parameter int unsigned DIG_PULSE_CYC = 8,
    parameter int unsigned CW            = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_busy_s,
    input  logic          ack_s,
    input  logic          lock_s,
    input  logic          full_req,
    input  logic          dig_req,
    input  logic [CW-1:0] cnt,
    output seq_state_e    state_o,
    output logic          restart_o,
    output logic          err_o
);

    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST    = CW'(ACK_TMO_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST  = CW'(DIG_PULSE_CYC - 1);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       tmo;
    logic       err_q;

    // Choose the next state from the synchronized status and the timer.
    always_comb begin
        state_d = state_q;
        tmo     = 1'b0;
        case (state_q)
            ST_CAL_WAIT: begin
                if (!cal_busy_s) state_d = ST_ANA_ASSERT;
            end
            ST_ANA_ASSERT: begin
                if (ack_s) begin
                    state_d = ST_ANA_RELEASE;
                end else if (cnt == TMO_LAST) begin
                    tmo = 1'b1;
                end
            end
            ST_ANA_RELEASE: begin
                if (!ack_s) begin
                    state_d = ST_LOCK_WAIT;
                end else if (cnt == TMO_LAST) begin
                    tmo     = 1'b1;
                    state_d = ST_ANA_ASSERT;
                end
            end
            ST_LOCK_WAIT: begin
                if (lock_s) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!lock_s) begin
                    state_d = ST_LOCK_WAIT;
                end else if (cnt == SETTLE_LAST) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (dig_req) begin
                    state_d = ST_DIG_PULSE;
                end else if (!lock_s) begin
                    state_d = ST_LOCK_WAIT;
                end
            end
            ST_DIG_PULSE: begin
                if (!lock_s) begin
                    state_d = ST_LOCK_WAIT;
                end else if (cnt == PULSE_LAST) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_CAL_WAIT;
        endcase
        if (full_req && state_q != ST_CAL_WAIT) begin
            state_d = ST_ANA_ASSERT;
        end
    end

    // Hold the current state and the one-cycle timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CAL_WAIT;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= tmo;
        end
    end

    assign restart_o = (state_d != state_q) || tmo
                       || (full_req && state_q != ST_CAL_WAIT);
    assign state_o   = state_q;
    assign err_o     = err_q;

endmodule

// File: rtl/rx_rst_seq.sv
// Receiver channel reset sequencer top. It synchronizes the status
// inputs, runs the sequencing state machine with one shared timer, and
// decodes the resets and ready from the state register.
// Assumes: CLK_FREQ_HZ is the true clk frequency, and every limit is >= 2.
module rx_rst_seq
    import rx_rst_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ   = 125_000_000,
    parameter int unsigned SETTLE_US     = 4,
    parameter int unsigned ACK_TMO_CYC   = 1000,
    parameter int unsigned DIG_PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_busy_i,
    input  logic ana_ack_i,
    input  logic cdr_lock_i,
    input  logic sw_full_req_i,
    input  logic sw_dig_req_i,
    output logic ana_rst_o,
    output logic dig_rst_o,
    output logic ready_o,
    output logic ack_err_o
);

    localparam longint unsigned SETTLE_PROD =
        longint'(CLK_FREQ_HZ) * longint'(SETTLE_US);
    localparam int unsigned SETTLE_CYC =
        int'((SETTLE_PROD + 64'd999_999) / 64'd1_000_000);
    localparam int unsigned MAX_A   = (SETTLE_CYC > ACK_TMO_CYC) ? SETTLE_CYC : ACK_TMO_CYC;
    localparam int unsigned CNT_MAX = (MAX_A > DIG_PULSE_CYC) ? MAX_A : DIG_PULSE_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    logic [2:0]    sync_s;
    logic [CW-1:0] cnt;
    logic          restart;
    seq_state_e    state;
    rst_out_t      outs;

    rx_rst_sync #(
        .W       (3),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cdr_lock_i, ana_ack_i, cal_busy_i}),
        .sync_o  (sync_s)
    );

    rx_rst_timer #(
        .CW (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .cnt_o (cnt)
    );

    rx_rst_fsm #(
        .SETTLE_CYC    (SETTLE_CYC),
        .ACK_TMO_CYC   (ACK_TMO_CYC),
        .DIG_PULSE_CYC (DIG_PULSE_CYC),
        .CW            (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_busy_s (sync_s[0]),
        .ack_s      (sync_s[1]),
        .lock_s     (sync_s[2]),
        .full_req   (sw_full_req_i),
        .dig_req    (sw_dig_req_i),
        .cnt        (cnt),
        .state_o    (state),
        .restart_o  (restart),
        .err_o      (ack_err_o)
    );

    // Resets and ready come straight from the state register.
    always_comb begin
        outs = seq_decode(state);
    end

    assign ana_rst_o = outs.ana;
    assign dig_rst_o = outs.dig;
    assign ready_o   = outs.rdy;

endmodule

// File: rtl/rx_rst_seq_chk.sv
// Port-level properties of the reset sequencer, bound to every instance.
// Assumes: each status input holds steady across two clock edges per change.
module rx_rst_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ana_ack_i,
    input logic cdr_lock_i,
    input logic sw_full_req_i,
    input logic sw_dig_req_i,
    input logic ana_rst_o,
    input logic dig_rst_o,
    input logic ready_o,
    input logic ack_err_o
);

    a_r6_ana_implies_dig: assert property (@(posedge clk) disable iff (!rst_n)
        ana_rst_o |-> dig_rst_o);

    a_r7_ready_match: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o == (!ana_rst_o && !dig_rst_o));

    a_r2_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ana_rst_o) |-> $past(ana_ack_i, 3));

    a_r4_release_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dig_rst_o) |-> $past(cdr_lock_i, 3));

    a_r8_dig_only_keeps_ana: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && sw_dig_req_i && !sw_full_req_i) |=> (dig_rst_o && !ana_rst_o));

    a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_o |=> !ack_err_o);

    a_r11_full_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sw_full_req_i |=> ana_rst_o);

endmodule

bind rx_rst_seq rx_rst_seq_chk u_rx_rst_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ana_ack_i     (ana_ack_i),
    .cdr_lock_i    (cdr_lock_i),
    .sw_full_req_i (sw_full_req_i),
    .sw_dig_req_i  (sw_dig_req_i),
    .ana_rst_o     (ana_rst_o),
    .dig_rst_o     (dig_rst_o),
    .ready_o       (ready_o),
    .ack_err_o     (ack_err_o)
);

// File: tb/rx_rst_seq_bench.sv
// Directed bench with a sweep over every lock-glitch position in the
// settling interval. Expected edges come from the requirement arithmetic.
module rx_rst_seq_bench;

    localparam int unsigned F_HZ  = 1_600_000;
    localparam int unsigned US    = 4;
    localparam int unsigned TMO   = 12;
    localparam int unsigned PULSE = 4;
    localparam int S = int'((longint'(F_HZ) * US + 999_999) / 1_000_000);

    logic clk = 1'b0;
    logic rst_n, cal_busy, ack, lock, full_req, dig_req;
    logic ana_rst, dig_rst, ready, ack_err;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    rx_rst_seq #(
        .CLK_FREQ_HZ   (F_HZ),
        .SETTLE_US     (US),
        .ACK_TMO_CYC   (TMO),
        .DIG_PULSE_CYC (PULSE)
    ) u_rx_rst_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cal_busy_i    (cal_busy),
        .ana_ack_i     (ack),
        .cdr_lock_i    (lock),
        .sw_full_req_i (full_req),
        .sw_dig_req_i  (dig_req),
        .ana_rst_o     (ana_rst),
        .dig_rst_o     (dig_rst),
        .ready_o       (ready),
        .ack_err_o     (ack_err)
    );

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        wrap_up();
    end

    initial begin
        rst_n = 1'b0; cal_busy = 1'b1; ack = 1'b0; lock = 1'b0;
        full_req = 1'b0; dig_req = 1'b0;
        cyc(3);
        chk("R1", "ana in reset", ana_rst, 1'b1);
        chk("R1", "dig in reset", dig_rst, 1'b1);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", "ready after reset", ready, 1'b0);
        chk("R1", "err after reset", ack_err, 1'b0);
        cyc(6);
        chk("R1", "ana while cal busy", ana_rst, 1'b1);
        chk("R1", "dig while cal busy", dig_rst, 1'b1);

        // R10: no acknowledge while waiting for it to rise
        cal_busy = 1'b0;
        cyc(2 + TMO);
        chk("R10", "err before timeout", ack_err, 1'b0);
        cyc(1);
        chk("R10", "err at timeout", ack_err, 1'b1);
        chk("R10", "ana held at timeout", ana_rst, 1'b1);
        cyc(1);
        chk("R10", "err one cycle", ack_err, 1'b0);

        // R2: acknowledge rises, analog release on the third edge
        ack = 1'b1;
        cyc(2);
        chk("R2", "ana before ack seen", ana_rst, 1'b1);
        cyc(1);
        chk("R2", "ana released", ana_rst, 1'b0);
        chk("R3", "dig held at ana release", dig_rst, 1'b1);

        // R3: lock is present but the acknowledge is still high
        lock = 1'b1;
        cyc(6);
        chk("R3", "dig while ack high", dig_rst, 1'b1);
        chk("R7", "ready while dig high", ready, 1'b0);
        ack = 1'b0;
        cyc(3 + S);
        chk("R3", "dig one edge before release", dig_rst, 1'b1);
        cyc(1);
        chk("R3", "dig released", dig_rst, 1'b0);
        chk("R7", "ready with both low", ready, 1'b1);

        // R9: loss of lock while ready
        lock = 1'b0;
        cyc(2);
        chk("R9", "dig before loss seen", dig_rst, 1'b0);
        cyc(1);
        chk("R9", "dig reasserted", dig_rst, 1'b1);
        chk("R9", "ana stays low", ana_rst, 1'b0);
        chk("R7", "ready drops", ready, 1'b0);

        // R4: lock returns in the lock wait
        lock = 1'b1;
        cyc(S + 2);
        chk("R4", "dig at SETTLE+2", dig_rst, 1'b1);
        cyc(1);
        chk("R4", "dig at SETTLE+3", dig_rst, 1'b0);

        // R5: one-cycle lock glitch at each settling position
        for (int d = 1; d <= S; d++) begin
            lock = 1'b0;
            cyc(3);
            chk("R9", "dig after loss in sweep", dig_rst, 1'b1);
            lock = 1'b1;
            cyc(d);
            lock = 1'b0;
            cyc(1);
            lock = 1'b1;
            cyc(S + 2);
            chk("R5", $sformatf("dig held after glitch at %0d", d), dig_rst, 1'b1);
            cyc(1);
            chk("R5", $sformatf("dig released after glitch at %0d", d), dig_rst, 1'b0);
        end

        // R8: digital-only pulse
        dig_req = 1'b1;
        cyc(1);
        dig_req = 1'b0;
        chk("R8", "dig pulse starts", dig_rst, 1'b1);
        chk("R8", "ana untouched", ana_rst, 1'b0);
        cyc(PULSE - 1);
        chk("R8", "dig pulse last cycle", dig_rst, 1'b1);
        chk("R8", "ana untouched at end", ana_rst, 1'b0);
        cyc(1);
        chk("R8", "dig pulse over", dig_rst, 1'b0);
        chk("R8", "ready returns", ready, 1'b1);

        // R11: full restart, then R10 timeout while waiting for the fall
        full_req = 1'b1;
        cyc(1);
        full_req = 1'b0;
        chk("R11", "ana asserted", ana_rst, 1'b1);
        chk("R6", "dig with ana", dig_rst, 1'b1);
        chk("R11", "ready low", ready, 1'b0);
        ack = 1'b1;
        cyc(3);
        chk("R2", "ana released after restart", ana_rst, 1'b0);
        cyc(TMO - 1);
        chk("R10", "err before release timeout", ack_err, 1'b0);
        cyc(1);
        chk("R10", "err at release timeout", ack_err, 1'b1);
        chk("R10", "ana retried", ana_rst, 1'b1);
        cyc(1);
        chk("R10", "ana released on retry", ana_rst, 1'b0);
        chk("R10", "err cleared", ack_err, 1'b0);
        ack = 1'b0;
        cyc(3 + S);
        chk("R4", "dig held after retry", dig_rst, 1'b1);
        cyc(1);
        chk("R4", "dig released after retry", dig_rst, 1'b0);
        chk("R7", "ready final", ready, 1'b1);

        wrap_up();
    end

endmodule